// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block turns the peripheral clock into the bit timing of an I2C controller. A single packed control word holds two fields. The low field sets a prescaler, which divides the peripheral clock into an internal tick. The high field sets how many of those ticks each SCL half-period lasts. The block drives SCL low through an open-drain style output. It gives the byte engine two single-cycle strobes: one to shift the next bit out while SCL is low, and one to sample the line while SCL is high.

Each low phase and each high phase lasts `10 + 4*step` ticks, so the fixed part of a period is `20 + 8*step` ticks. After the block releases SCL, it adds a measured wait: the high phase only begins once the synchronized SCL input reads high. This wait covers rise time and internal delay. It also lets a slave stretch the clock by holding the line low.

Writing the control word starts the clock and restarts the divider. Dropping the master enable parks the divider and releases SCL.

Top module: `scl_clock_divider`

## Requirements
- R1: While `rst` is high or `mst_en` is low, `tick`, `sample_stb` and `shift_stb` are 0. One cycle after `mst_en` is seen low, `scl_low` is 0.
- R2: After reset, no tick, strobe or SCL drive occurs until the first `ccr_wr`, even with `mst_en` high.
- R3: The control word places the prescale value in bits `[CDF_W-1:0]` and the 6-bit period step in bits `[CDF_W+5:CDF_W]`. `CDF_W` is a parameter (2 or 3, default 3). A write takes effect from the next cycle and restarts the divider.
- R4: While running, `tick` is a single-cycle pulse every `prescale+1` clock cycles. With a prescale of 0 it is high on every cycle.
- R5: Every low phase holds `scl_low` high for exactly `(10+4*step)*(prescale+1)` cycles.
- R6: The high-phase count starts at the first tick on which the SCL input, passed through two synchronizing flops, reads high. With no stretching, SCL stays released for exactly `(w + 10+4*step)*(prescale+1)` cycles, where `w` is 3, 2 or 1 for a prescale of 0, 1 or 2 and above.
- R7: While the SCL input is held low after release, `scl_low` stays 0 and no `sample_stb` occurs. Once the input rises, SCL is driven low again between `(10+4*step)*(prescale+1)+3` and `(10+4*step)*(prescale+1)+2+(prescale+1)` cycles later, counting the first high cycle as 1.
- R8: `shift_stb` pulses exactly once per low phase, on low cycle `(5+2*step)*(prescale+1)`, counting the first low cycle as 1.
- R9: `sample_stb` pulses exactly once per high phase, while SCL is released. It comes exactly `(5+2*step)*(prescale+1)` cycles before the last released cycle.
- R10: A control word written once is kept across `mst_en` low. Re-enabling restarts the periods with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_en | input | 1 | Master interface enable |
| ccr_wr | input | 1 | Control word write strobe |
| ccr_data | input | CDF_W+6 | Packed control word: step above prescale |
| scl_in | input | 1 | Sensed SCL line level (asynchronous) |
| scl_low | output | 1 | 1 = pull SCL low, 0 = release |
| tick | output | 1 | Internal tick enable |
| sample_stb | output | 1 | Mid-high-phase sample strobe |
| shift_stb | output | 1 | Mid-low-phase shift strobe |

## Verification
Every timing result is counted in clock cycles from an edge of `scl_low` seen at the ports. This covers the low width, the released width, the strobe offsets and the gap between ticks. The bench samples on the falling clock edge, so a result that is due k rising edges after its cause is seen k sample points later.

The released-width check ties the tick grid to the two-flop input path. The expected wait is 3, 2 or 1 tick for each prescale value. Measurement always skips the first period after a write or enable, because that period is not aligned to the tick grid.

For stretching, the release instant of the slave is not tick-aligned. The bench therefore checks a window one tick wide, derived in R7.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    // Ticks per SCL half period = HALF_BASE + HALF_STEP * step
    localparam int HALF_BASE = 10;
    localparam int HALF_STEP = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_HIGH = 2'd2,
        PH_LOW  = 2'd3
    } scl_phase_e;

    function automatic int half_ticks_max(input int step_w);
        return HALF_BASE + HALF_STEP * ((1 << step_w) - 1);
    endfunction
endpackage

// File: rtl/scl_ccr_reg.sv
module scl_ccr_reg #(
    parameter int CDF_W  = 3,
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CDF_W+STEP_W-1:0] wdata,
    output logic [CDF_W-1:0]  cdf,
    output logic [STEP_W-1:0] step,
    output logic              loaded
);
    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [CDF_W-1:0]  cdf;
    } ccr_t;

    ccr_t ccr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_q  <= '0;
            loaded <= 1'b0;
        end else if (wr) begin
            ccr_q  <= ccr_t'(wdata);
            loaded <= 1'b1;
        end
    end

    assign cdf  = ccr_q.cdf;
    assign step = ccr_q.step;
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int CDF_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CDF_W-1:0] cdf,
    output logic             tick
);
    logic [CDF_W-1:0] pre_cnt;

    assign tick = run && (pre_cnt == cdf);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + CDF_W'(1);
        end
    end
endmodule

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '1;
        end else begin
            sr <= {sr[STAGES-2:0], d};
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_div_pkg::*;
#(
    parameter int PH_W = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            tick,
    input  logic            scl_hi,
    input  logic [PH_W-1:0] phase_len,
    output logic            scl_low,
    output logic            sample_stb,
    output logic            shift_stb
);
    scl_phase_e      state;
    logic [PH_W-1:0] cnt;
    logic [PH_W-1:0] mid;
    logic            last;

    assign mid  = (phase_len >> 1) - PH_W'(1);
    assign last = (cnt == phase_len - PH_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                PH_IDLE: begin
                    state <= PH_WAIT;
                    cnt   <= '0;
                end
                PH_WAIT: begin
                    if (tick && scl_hi) begin
                        state <= PH_HIGH;
                        cnt   <= '0;
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        if (last) begin
                            state <= PH_LOW;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + PH_W'(1);
                        end
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (last) begin
                            state <= PH_WAIT;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + PH_W'(1);
                        end
                    end
                end
                default: begin
                    state <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign scl_low    = (state == PH_LOW);
    assign sample_stb = tick && (state == PH_HIGH) && (cnt == mid);
    assign shift_stb  = tick && (state == PH_LOW) && (cnt == mid);
endmodule

// File: rtl/scl_clock_divider.sv
module scl_clock_divider
    import scl_div_pkg::*;
#(
    parameter int CDF_W  = 3,
    parameter int STEP_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mst_en,
    input  logic                    ccr_wr,
    input  logic [CDF_W+STEP_W-1:0] ccr_data,
    input  logic                    scl_in,
    output logic                    scl_low,
    output logic                    tick,
    output logic                    sample_stb,
    output logic                    shift_stb
);
    localparam int PH_W = $clog2(half_ticks_max(STEP_W) + 1);

    logic [CDF_W-1:0]  cdf;
    logic [STEP_W-1:0] step;
    logic              cfg_loaded;
    logic              run;
    logic              scl_hi;
    logic [PH_W-1:0]   phase_len;

    scl_ccr_reg #(.CDF_W(CDF_W), .STEP_W(STEP_W)) u_ccr (
        .clk(clk), .rst(rst), .wr(ccr_wr), .wdata(ccr_data),
        .cdf(cdf), .step(step), .loaded(cfg_loaded)
    );

    // A control write restarts the divider; running needs a prior write
    assign run = mst_en && cfg_loaded && !ccr_wr && !rst;

    assign phase_len = PH_W'(HALF_BASE) + PH_W'(step) * PH_W'(HALF_STEP);

    scl_prescaler #(.CDF_W(CDF_W)) u_pre (
        .clk(clk), .rst(rst), .run(run), .cdf(cdf), .tick(tick)
    );

    scl_in_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(scl_in), .q(scl_hi)
    );

    scl_phase_fsm #(.PH_W(PH_W)) u_fsm (
        .clk(clk), .rst(rst), .run(run), .tick(tick), .scl_hi(scl_hi),
        .phase_len(phase_len), .scl_low(scl_low),
        .sample_stb(sample_stb), .shift_stb(shift_stb)
    );
endmodule

// File: rtl/scl_div_checker.sv
module scl_div_checker (
    input logic clk,
    input logic rst,
    input logic mst_en,
    input logic ccr_wr,
    input logic loaded,
    input logic scl_low,
    input logic tick,
    input logic sample_stb,
    input logic shift_stb
);
    p_quiet_off_r1: assert property (@(posedge clk) disable iff (rst)
        !mst_en |-> (!tick && !sample_stb && !shift_stb));

    p_release_off_r1: assert property (@(posedge clk) disable iff (rst)
        !mst_en |=> !scl_low);

    p_no_tick_unloaded_r2: assert property (@(posedge clk) disable iff (rst)
        !loaded |-> (!tick && !scl_low));

    p_strobe_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        (sample_stb || shift_stb) |-> tick);

    p_low_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (scl_low && !tick && mst_en && !ccr_wr) |=> scl_low);

    p_shift_in_low_r8: assert property (@(posedge clk) disable iff (rst)
        shift_stb |-> scl_low);

    p_sample_released_r9: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> !scl_low);
endmodule

bind scl_clock_divider scl_div_checker u_chk (
    .clk(clk), .rst(rst), .mst_en(mst_en), .ccr_wr(ccr_wr),
    .loaded(cfg_loaded), .scl_low(scl_low), .tick(tick),
    .sample_stb(sample_stb), .shift_stb(shift_stb)
);

// File: tb/tb_scl_clock_divider.sv
module tb_scl_clock_divider;
    localparam int CDF_W  = 3;
    localparam int STEP_W = 6;
    localparam int GUARD  = 5000;

    logic clk = 1'b0;
    logic rst, mst_en, ccr_wr, stretch;
    logic [CDF_W+STEP_W-1:0] ccr_data;
    logic scl_low, tick, sample_stb, shift_stb;
    logic scl_in;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    // Open-drain line: low if master drives or slave stretches
    assign scl_in = !scl_low && !stretch;

    scl_clock_divider #(.CDF_W(CDF_W), .STEP_W(STEP_W)) dut (
        .clk(clk), .rst(rst), .mst_en(mst_en), .ccr_wr(ccr_wr),
        .ccr_data(ccr_data), .scl_in(scl_in), .scl_low(scl_low),
        .tick(tick), .sample_stb(sample_stb), .shift_stb(shift_stb)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_ccr(input int cdf, input int step);
        @(negedge clk);
        ccr_data = {STEP_W'(step), CDF_W'(cdf)};
        ccr_wr   = 1'b1;
        @(negedge clk);
        ccr_wr   = 1'b0;
    endtask

    task automatic wait_low_rise(output bit ok);
        logic prev;
        int   g;
        prev = scl_low;
        g = 0;
        ok = 1'b0;
        while (g < GUARD) begin
            @(negedge clk);
            g++;
            if (!prev && scl_low) begin
                ok = 1'b1;
                break;
            end
            prev = scl_low;
        end
    endtask

    // Measures one full low + released interval (R3, R5, R6, R8, R9)
    task automatic t_period(input int cdf, input int step);
        int d, pt, w, low_len, rel_len, sh_n, sh_at, sa_n, sa_at, g;
        bit ok;
        d  = cdf + 1;
        pt = 10 + 4 * step;
        w  = (d >= 3) ? 1 : ((d == 2) ? 2 : 3);
        write_ccr(cdf, step);
        wait_low_rise(ok);
        wait_low_rise(ok);
        chk(ok, "R3", "low phase seen after write", int'(ok), 1);
        low_len = 0; sh_n = 0; sh_at = 0; g = 0;
        while (scl_low && g < GUARD) begin
            low_len++; g++;
            if (shift_stb) begin sh_n++; sh_at = low_len; end
            @(negedge clk);
        end
        rel_len = 0; sa_n = 0; sa_at = 0; g = 0;
        while (!scl_low && g < GUARD) begin
            rel_len++; g++;
            if (sample_stb) begin sa_n++; sa_at = rel_len; end
            @(negedge clk);
        end
        chk(low_len == pt * d, "R5", "low width", low_len, pt * d);
        chk(sh_n == 1, "R8", "shift strobes per low", sh_n, 1);
        chk(sh_at == (pt / 2) * d, "R8", "shift offset", sh_at, (pt / 2) * d);
        chk(rel_len == (w + pt) * d, "R6", "released width", rel_len, (w + pt) * d);
        chk(sa_n == 1, "R9", "sample strobes per high", sa_n, 1);
        chk(rel_len - sa_at == (pt / 2) * d, "R9", "sample to end",
            rel_len - sa_at, (pt / 2) * d);
    endtask

    // Tick spacing (R4)
    task automatic t_tick(input int cdf);
        int gap, g;
        write_ccr(cdf, 0);
        g = 0;
        while (!tick && g < GUARD) begin @(negedge clk); g++; end
        gap = 0;
        @(negedge clk);
        gap = 1;
        while (!tick && gap < GUARD) begin @(negedge clk); gap++; end
        chk(gap == cdf + 1, "R4", "tick spacing", gap, cdf + 1);
        @(negedge clk);
        if (cdf > 0) chk(!tick, "R4", "tick single cycle", int'(tick), 0);
    endtask

    task automatic t_reset_idle();
        int seen;
        rst = 1'b1; mst_en = 1'b1; ccr_wr = 1'b0; ccr_data = '0; stretch = 1'b0;
        repeat (3) @(negedge clk);
        chk(!scl_low && !tick && !sample_stb && !shift_stb, "R1", "outputs in reset",
            int'({scl_low, tick, sample_stb, shift_stb}), 0);
        rst = 1'b0;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tick || scl_low || sample_stb || shift_stb) seen++;
        end
        chk(seen == 0, "R2", "activity before first write", seen, 0);
    endtask

    task automatic t_stretch();
        int d, pt, held_bad, n, g;
        bit ok;
        d = 2; pt = 10;
        write_ccr(1, 0);
        wait_low_rise(ok);
        stretch = 1'b1;
        g = 0;
        while (scl_low && g < GUARD) begin @(negedge clk); g++; end
        held_bad = 0;
        for (int i = 0; i < 30; i++) begin
            if (scl_low || sample_stb) held_bad++;
            @(negedge clk);
        end
        chk(held_bad == 0, "R7", "no drive or sample while stretched", held_bad, 0);
        stretch = 1'b0;
        n = 0;
        while (!scl_low && n < GUARD) begin @(negedge clk); n++; end
        chk(n >= pt * d + 3 && n <= pt * d + 2 + d, "R7", "stretch resume window",
            n, pt * d + 3);
    endtask

    task automatic t_disable();
        bit ok;
        int bad;
        write_ccr(2, 1);
        wait_low_rise(ok);
        repeat (5) @(negedge clk);
        mst_en = 1'b0;
        @(negedge clk);
        chk(!scl_low && !tick, "R1", "release after disable",
            int'({scl_low, tick}), 0);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (scl_low || tick || sample_stb || shift_stb) bad++;
        end
        chk(bad == 0, "R1", "quiet while disabled", bad, 0);
        mst_en = 1'b1;
        wait_low_rise(ok);
        wait_low_rise(ok);
        bad = 0;
        while (scl_low && bad < GUARD) begin bad++; @(negedge clk); end
        chk(bad == 14 * 3, "R10", "low width after re-enable", bad, 42);
    endtask

    initial begin
        #1_500_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset_idle();
        t_tick(0);
        t_tick(3);
        t_period(0, 0);
        t_period(2, 1);
        t_period(7, 3);
        t_period(1, 63);
        t_stretch();
        t_disable();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule